// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block forms the full-width product of two unsigned operands. It does one add-and-shift step per clock and one step per multiplier bit. A start strobe captures the multiplicand into its own register. The same strobe places the multiplier in the lower half of a double-width accumulator and clears the upper half. After that the block steps through every multiplier bit. It raises a one-cycle completion flag and then holds the product until the next start.

Each step adds the upper half of the accumulator to either the multiplicand or zero. The choice depends on the accumulator's least significant bit. The adder is a separate combinational carry-select adder made of groups that widen along the carry path, so the worst-case carry sees roughly the square root of the width in select stages. The adder's carry-out and sum are shifted right together with the lower half, so no carry is lost.

With the default parameters the operands are 32 bits, the product is 64 bits and a multiplication takes 32 steps.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset, busy and done are 0 and the product output is all zeros.
- R2: The carry-select adder returns {carry-out, sum} equal to the full-precision value a + b + cin for every operand value, including the case where an all-ones operand is added to one.
- R3: A start sampled while idle loads the multiplicand. In the next cycle busy is 1 and the product output reads {zeros, multiplier operand}, with the multiplier in the low half.
- R4: In each busy cycle, if product bit 0 is 1 the multiplicand is added to the upper half, otherwise zero is added. The 33-bit result and the lower half then shift right by one, and the carry-out enters the most significant bit.
- R5: Exactly WIDTH steps follow the load. Busy falls and done rises WIDTH cycles after the loading edge.
- R6: Done is high for exactly one cycle, and in that cycle the product equals op_a × op_b.
- R7: While idle and without a start, the product output does not change, whatever the operand inputs do.
- R8: A start while busy has no effect. The running multiplication keeps its operands and timing and finishes with the original product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiplication when idle |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle completion flag |
| product | output | 2*WIDTH | Accumulator and final product |

## Verification
The load assertion compares the product one cycle after a start with the operand value on the start edge. It therefore assumes op_b was stable and valid at that edge. The bench drives all inputs only on falling edges to meet this. The hold assertions expect start to be a clean sampled level. The bench raises start for a single cycle, both when idle and in the mid-run case that must be ignored. Operands are corner values (zero, one, all ones) and random pairs. Each is compared against a cycle-level reference model and against the exact wide product.

// File: rtl/mul_pkg.sv
package mul_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mul_state_t;

   // Width of carry-select group i: two groups of the base width, then one bit wider per group.
   function automatic int grp_size(input int first, input int i);
      return (i == 0) ? first : first + i - 1;
   endfunction

   function automatic int grp_lo(input int first, input int i);
      int lo;
      lo = 0;
      for (int k = 0; k < i; k++) lo += grp_size(first, k);
      return lo;
   endfunction

   function automatic int grp_count(input int first, input int width);
      int n;
      int lo;
      n  = 0;
      lo = 0;
      while (lo < width) begin
         lo += grp_size(first, n);
         n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/csla_block.sv
module csla_block #(
   parameter int W          = 4,
   parameter bit OPT_SELECT = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] s0;
   logic [W:0] s1;

   if (W < 1) begin : g_bad_w
      $error("csla_block: W must be at least 1");
   end

   assign s0 = {1'b0, a} + {1'b0, b};
   assign s1 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};

   assign sum = cin ? s1[W-1:0] : s0[W-1:0];

   if (OPT_SELECT) begin : g_andor
      // A carry from the zero-input path implies a carry from the one-input path.
      assign cout = s0[W] | (cin & s1[W]);
   end else begin : g_mux
      assign cout = cin ? s1[W] : s0[W];
   end

   // R2: carry ordering the AND-OR select relies on
   always_comb begin
      a_r2_carry_order: assert (!s0[W] || s1[W])
         else $error("carry path ordering violated");
   end
endmodule

// File: rtl/sqrt_csla.sv
module sqrt_csla
   import mul_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int FIRST      = 2,
   parameter bit OPT_SELECT = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int NGRP = grp_count(FIRST, WIDTH);

   logic [NGRP:0] cy;

   if (WIDTH < 2) begin : g_bad_width
      $error("sqrt_csla: WIDTH must be at least 2");
   end
   if (FIRST < 1) begin : g_bad_first
      $error("sqrt_csla: FIRST must be at least 1");
   end

   assign cy[0] = cin;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LO  = grp_lo(FIRST, g);
      localparam int RAW = grp_size(FIRST, g);
      localparam int SZ  = (RAW < WIDTH - LO) ? RAW : WIDTH - LO;
      if (g == 0) begin : g_ripple
         assign {cy[g+1], sum[LO +: SZ]} =
            {1'b0, a[LO +: SZ]} + {1'b0, b[LO +: SZ]} + {{SZ{1'b0}}, cy[g]};
      end else begin : g_select
         csla_block #(.W(SZ), .OPT_SELECT(OPT_SELECT)) u_blk (
            .a   (a[LO +: SZ]),
            .b   (b[LO +: SZ]),
            .cin (cy[g]),
            .sum (sum[LO +: SZ]),
            .cout(cy[g+1])
         );
      end
   end

   assign cout = cy[NGRP];

   // R2: grouped structure agrees with full-precision addition
   always_comb begin
      a_r2_adder_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("carry-select sum mismatch");
   end
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
   import mul_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int FIRST      = 2,
   parameter bit OPT_SELECT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);
   localparam int PW = 2 * WIDTH;
   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("shiftadd_mult: WIDTH must be at least 2");
   end

   mul_state_t        state;
   logic [PW-1:0]     acc;
   logic [WIDTH-1:0]  mcand;
   logic [CW-1:0]     step;
   logic              done_q;

   logic [WIDTH-1:0]  addend;
   logic [WIDTH-1:0]  upper_sum;
   logic              upper_co;
   logic [PW-1:0]     acc_next;

   assign addend = acc[0] ? mcand : '0;

   sqrt_csla #(.WIDTH(WIDTH), .FIRST(FIRST), .OPT_SELECT(OPT_SELECT)) u_add (
      .a   (acc[PW-1:WIDTH]),
      .b   (addend),
      .cin (1'b0),
      .sum (upper_sum),
      .cout(upper_co)
   );

   assign acc_next = {upper_co, upper_sum, acc[WIDTH-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         acc    <= '0;
         mcand  <= '0;
         step   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  mcand <= op_a;
                  acc   <= {{WIDTH{1'b0}}, op_b};
                  step  <= '0;
                  state <= ST_RUN;
               end
            end
            ST_RUN: begin
               acc  <= acc_next;
               step <= step + 1'b1;
               if (step == LAST) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state == ST_RUN);
   assign done    = done_q;
   assign product = acc;

   // R3: a start while idle loads the accumulator
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && product == {{WIDTH{1'b0}}, $past(op_b)}))
      else $error("load mismatch");

   // R4: one step shifts right by one, carry into the top bit
   a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (product[WIDTH-2:0] == $past(product[WIDTH-1:1])))
      else $error("shift mismatch");

   // R5: completion coincides with the end of busy
   a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done)
      else $error("busy fell without done");

   // R6: done lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   // R7: product held while idle
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product))
      else $error("product changed while idle");

   // R8: multiplicand untouched while running
   a_r8_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mcand))
      else $error("multiplicand changed while busy");
endmodule

// File: tb/shiftadd_mult_test.sv
`timescale 1ns/1ps
module shiftadd_mult_test;
   localparam int W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [W-1:0]    op_a = '0;
   logic [W-1:0]    op_b = '0;
   logic            busy;
   logic            done;
   logic [2*W-1:0]  product;

   logic [W-1:0]    ad_a = '0;
   logic [W-1:0]    ad_b = '0;
   logic            ad_ci = 1'b0;
   logic [W-1:0]    ad_s;
   logic            ad_co;

   int n_tests = 0;
   int n_fail  = 0;
   bit model_on = 1'b0;

   always #2.5 clk = ~clk;

   shiftadd_mult #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .product(product)
   );

   sqrt_csla #(.WIDTH(W)) add_uut (
      .a(ad_a), .b(ad_b), .cin(ad_ci), .sum(ad_s), .cout(ad_co)
   );

   // behavioural reference, updated from the spec on each rising edge
   logic            m_busy = 1'b0;
   logic            m_done = 1'b0;
   logic [2*W-1:0]  m_prod = '0;
   logic [W-1:0]    m_mc = '0;
   int              m_cnt = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_prod <= '0; m_mc <= '0; m_cnt <= 0;
      end else if (!m_busy) begin
         m_done <= 1'b0;
         if (start) begin
            m_mc <= op_a; m_prod <= {{W{1'b0}}, op_b}; m_busy <= 1'b1; m_cnt <= 0;
         end
      end else begin
         logic [W:0] t;
         t = {1'b0, m_prod[2*W-1:W]} + {1'b0, (m_prod[0] ? m_mc : {W{1'b0}})};
         m_prod <= {t, m_prod[W-1:1]};
         m_cnt  <= m_cnt + 1;
         m_done <= 1'b0;
         if (m_cnt == W - 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
      end
   end

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         check(busy == m_busy, "R5 busy vs model", 128'(busy), 128'(m_busy));
         check(done == m_done, "R6 done vs model", 128'(done), 128'(m_done));
         check(product == m_prod, "R4 product vs model", 128'(product), 128'(m_prod));
      end
   end

   task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
      int n;
      logic [2*W-1:0] exp;
      exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R3 busy after start", 128'(busy), 128'(1));
      check(product == {{W{1'b0}}, b}, "R3 loaded product", 128'(product), 128'({{W{1'b0}}, b}));
      n = 1;
      while (!done) begin
         if (poke && n == 10) begin op_a = ~a; op_b = b ^ 32'h5a5a_1234; start = 1'b1; end
         else start = 1'b0;
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      check(n == W + 1, "R5 step count", 128'(n), 128'(W + 1));
      check(product == exp, poke ? "R8 product after ignored start" : "R6 final product",
            128'(product), 128'(exp));
      @(negedge clk);
      check(done == 1'b0, "R6 done single cycle", 128'(done), 128'(0));
      op_a = $urandom; op_b = $urandom;
      repeat (3) @(negedge clk);
      check(product == exp, "R7 product held while idle", 128'(product), 128'(exp));
   endtask

   task automatic add_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
      logic [W:0] exp;
      exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      ad_a = a; ad_b = b; ad_ci = ci;
      #1;
      check({ad_co, ad_s} == exp, "R2 adder", 128'({ad_co, ad_s}), 128'(exp));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1 reset busy", 128'(busy), 128'(0));
      check(done == 1'b0, "R1 reset done", 128'(done), 128'(0));
      check(product == '0, "R1 reset product", 128'(product), 128'(0));
      model_on = 1'b1;

      add_vec('1, 32'd1, 1'b0);
      add_vec('1, '1, 1'b1);
      add_vec('0, '0, 1'b1);
      add_vec(32'h0000_ffff, 32'h0000_0001, 1'b0);
      for (int i = 0; i < 20; i++) add_vec($urandom, $urandom, 1'($urandom));

      run_mul(32'd0, 32'd12345, 1'b0);
      run_mul(32'hdead_beef, 32'd0, 1'b0);
      run_mul(32'd1, 32'hffff_ffff, 1'b0);
      run_mul(32'hffff_ffff, 32'd1, 1'b0);
      run_mul(32'hffff_ffff, 32'hffff_ffff, 1'b0);
      run_mul(32'h8000_0000, 32'h8000_0000, 1'b0);
      run_mul(32'h1234_5678, 32'h9abc_def0, 1'b1);
      for (int i = 0; i < 20; i++) run_mul($urandom, $urandom, 1'b0);

      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule